// File: doc/BRIEF.md
# Normalising barrel shifter

This block shifts a 16-bit word under a 4-bit opcode. It can shift left or right logically, shift right arithmetically, or rotate in either direction. The shift count comes from one of four places: a 4-bit count captured from the count port, one of two 4-bit count stores that the block keeps, or a leading-sign encoder. The encoder finds how far the word must move left to drop its redundant sign bits. Normalise opcodes use the encoder count, can write it into a count store, and can drive it out on the count port.

The opcode, the data word and the count port are captured together on a rising clock edge. The result is shown during the following cycle. Count-store writes take effect on the edge that ends that cycle. The count port is modelled as three wires: an input, an output and an output enable. A strap input holds the port in input-only mode. A synchronous clear empties both count stores and the captured count.

Top module: `norm_shifter`

## Requirements
- R1: Opcode 0 shifts the captured data right by the captured count, and opcode 1 shifts it left by the same count. Vacated bits fill with zero and bits pushed out are lost.
- R2: Opcode 2 rotates the captured data right by the captured count, and opcode 3 rotates it left. Bits leaving one end re-enter at the other end.
- R3: Opcode 10 shifts right arithmetically by the captured count. Opcodes 11 and 12 do the same using count store 0 and count store 1. Vacated high bits copy the original bit 15.
- R4: Opcodes 4 and 5 shift logically right and left by the value in count store 0. Opcodes 6 and 7 do the same with count store 1.
- R5: Opcodes 8 and 9 pass the data through unshifted. On the edge ending that cycle, opcode 8 writes the captured count into count store 0 and opcode 9 writes it into count store 1.
- R6: Opcodes 13, 14 and 15 shift left, filling with zeros, by the encoder count. The encoder count is the number of consecutive bits below bit 15, starting at bit 14, that equal bit 15. An all-zero or all-ones word gives 15. For any other word, bits 15 and 14 of the result differ.
- R7: On the edge ending its cycle, opcode 14 writes the encoder count into count store 0 and opcode 15 writes it into count store 1.
- R8: The count port output enable is high only while opcode 13, 14 or 15 executes and the strap is low. While the enable is high, the count output carries the encoder count. With the strap high the enable stays low for every opcode.
- R9: A synchronous clear zeroes both count stores and the captured count on that edge. Any count-store write due on the same edge is dropped. The opcode and data are still captured.
- R10: While reset is low, all internal state is zero, the data output reads 0 and the output enable is low, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of count stores and captured count |
| op_in | input | 4 | Opcode, captured on the clock edge |
| data_in | input | 16 | Data word, captured on the clock edge |
| amt_in | input | 4 | Count port input side, captured on the clock edge |
| amt_in_only | input | 1 | Strap: high keeps the count port an input |
| data_out | output | 16 | Shift result of the executing opcode |
| amt_out | output | 4 | Count port output side (encoder count) |
| amt_oe | output | 1 | Count port output enable |

## Verification
A result is due in the cycle after the rising edge that captures its opcode, data and count. The bench drives each operation on a falling edge and samples the data output, the enable and the count output on the next falling edge, one period later. A count-store write lands on the edge that captures the next operation, so the bench checks each write through the following opcode that shifts by that store. A clear is modelled as zeroing the stores before the operation that carries it is evaluated, which also covers the dropped write from the operation before it.

// File: rtl/norm_shifter_pkg.sv
package norm_shifter_pkg;

   typedef enum logic [1:0] {
      SK_LOGIC = 2'd0,
      SK_ARITH = 2'd1,
      SK_ROT   = 2'd2
   } shift_kind_e;

   typedef enum logic [2:0] {
      AS_NONE = 3'd0,
      AS_CAP  = 3'd1,
      AS_ST0  = 3'd2,
      AS_ST1  = 3'd3,
      AS_ENC  = 3'd4
   } amt_src_e;

   typedef struct packed {
      amt_src_e    src;
      shift_kind_e kind;
      logic        left;
      logic        wr0;
      logic        wr1;
      logic        norm;
   } shift_ctl_t;

   function automatic shift_ctl_t decode_op(input logic [3:0] op);
      shift_ctl_t c;
      c.src  = AS_NONE;
      c.kind = SK_LOGIC;
      c.left = 1'b0;
      c.wr0  = 1'b0;
      c.wr1  = 1'b0;
      c.norm = 1'b0;
      case (op)
         4'h0: c.src = AS_CAP;
         4'h1: begin c.src = AS_CAP; c.left = 1'b1; end
         4'h2: begin c.src = AS_CAP; c.kind = SK_ROT; end
         4'h3: begin c.src = AS_CAP; c.kind = SK_ROT; c.left = 1'b1; end
         4'h4: c.src = AS_ST0;
         4'h5: begin c.src = AS_ST0; c.left = 1'b1; end
         4'h6: c.src = AS_ST1;
         4'h7: begin c.src = AS_ST1; c.left = 1'b1; end
         4'h8: c.wr0 = 1'b1;
         4'h9: c.wr1 = 1'b1;
         4'hA: begin c.src = AS_CAP; c.kind = SK_ARITH; end
         4'hB: begin c.src = AS_ST0; c.kind = SK_ARITH; end
         4'hC: begin c.src = AS_ST1; c.kind = SK_ARITH; end
         4'hD: begin c.src = AS_ENC; c.left = 1'b1; c.norm = 1'b1; end
         4'hE: begin c.src = AS_ENC; c.left = 1'b1; c.norm = 1'b1; c.wr0 = 1'b1; end
         default: begin c.src = AS_ENC; c.left = 1'b1; c.norm = 1'b1; c.wr1 = 1'b1; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/lead_sign_enc.sv
module lead_sign_enc #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   output logic [CNT_W-1:0]  cnt
);
   logic run;

   always_comb begin
      cnt = '0;
      run = 1'b1;
      for (int i = DATA_W - 2; i >= 0; i--) begin
         if (run && (din[i] == din[DATA_W-1])) cnt = cnt + 1'b1;
         else run = 1'b0;
      end
   end
endmodule

// File: rtl/shift_core.sv
module shift_core
   import norm_shifter_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = $clog2(DATA_W),
   parameter bit STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  amt,
   input  shift_kind_e       kind,
   input  logic              left,
   output logic [DATA_W-1:0] dout
);
   logic fill;
   assign fill = (kind == SK_ARITH) & din[DATA_W-1];

   generate
      if (STAGED) begin : g_staged
         logic [CNT_W:0][DATA_W-1:0] stg;
         assign stg[0] = din;
         for (genvar i = 0; i < CNT_W; i++) begin : g_stage
            localparam int S = 1 << i;
            assign stg[i+1] =
               !amt[i]          ? stg[i] :
               (kind == SK_ROT) ? (left ? {stg[i][DATA_W-1-S:0], stg[i][DATA_W-1:DATA_W-S]}
                                        : {stg[i][S-1:0], stg[i][DATA_W-1:S]}) :
               left             ? {stg[i][DATA_W-1-S:0], {S{1'b0}}}
                                : {{S{fill}}, stg[i][DATA_W-1:S]};
         end
         assign dout = stg[CNT_W];
      end else begin : g_flat
         logic [2*DATA_W-1:0] dbl_r, dbl_l;
         always_comb begin
            dbl_r = {din, din} >> amt;
            dbl_l = {din, din} << amt;
            if (kind == SK_ROT) dout = left ? dbl_l[2*DATA_W-1:DATA_W] : dbl_r[DATA_W-1:0];
            else if (left)      dout = din << amt;
            else                dout = (din >> amt) | ~({DATA_W{1'b1}} >> amt) & {DATA_W{fill}};
         end
      end
   endgenerate
endmodule

// File: rtl/norm_ctrl.sv
module norm_ctrl #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] amt_in,
   input  logic             wr0,
   input  logic             wr1,
   input  logic             use_enc,
   input  logic [CNT_W-1:0] enc_cnt,
   output logic [CNT_W-1:0] cap_q,
   output logic [CNT_W-1:0] st0_q,
   output logic [CNT_W-1:0] st1_q
);
   logic [CNT_W-1:0] wr_val;
   assign wr_val = use_enc ? enc_cnt : cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cap_q <= '0;
         st0_q <= '0;
         st1_q <= '0;
      end else begin
         cap_q <= amt_in;
         if (wr0) st0_q <= wr_val;
         if (wr1) st1_q <= wr_val;
      end
   end

   // R9
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st0_q == '0 && st1_q == '0 && cap_q == '0));
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
   import norm_shifter_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit STAGED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic [3:0]                 op_in,
   input  logic [DATA_W-1:0]          data_in,
   input  logic [$clog2(DATA_W)-1:0]  amt_in,
   input  logic                       amt_in_only,
   output logic [DATA_W-1:0]          data_out,
   output logic [$clog2(DATA_W)-1:0]  amt_out,
   output logic                       amt_oe
);
   localparam int CNT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("norm_shifter: DATA_W must be a power of two, at least 4");
      end
   endgenerate

   logic [3:0]        op_q;
   logic [DATA_W-1:0] data_q;
   shift_ctl_t        ctl;
   logic [CNT_W-1:0]  enc_cnt, cap_q, st0_q, st1_q, amt_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= '0;
         data_q <= '0;
      end else begin
         op_q   <= op_in;
         data_q <= data_in;
      end
   end

   assign ctl = decode_op(op_q);

   lead_sign_enc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_enc (
      .din (data_q),
      .cnt (enc_cnt)
   );

   norm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .amt_in  (amt_in),
      .wr0     (ctl.wr0),
      .wr1     (ctl.wr1),
      .use_enc (ctl.norm),
      .enc_cnt (enc_cnt),
      .cap_q   (cap_q),
      .st0_q   (st0_q),
      .st1_q   (st1_q)
   );

   always_comb begin
      case (ctl.src)
         AS_CAP:  amt_sel = cap_q;
         AS_ST0:  amt_sel = st0_q;
         AS_ST1:  amt_sel = st1_q;
         AS_ENC:  amt_sel = enc_cnt;
         default: amt_sel = '0;
      endcase
   end

   shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .STAGED(STAGED)) u_core (
      .din  (data_q),
      .amt  (amt_sel),
      .kind (ctl.kind),
      .left (ctl.left),
      .dout (data_out)
   );

   assign amt_out = enc_cnt;
   assign amt_oe  = ctl.norm & ~amt_in_only;

   // R5
   pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == 4'h8 || op_q == 4'h9) |-> data_out == data_q);
   // R2
   rot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == 4'h2 || op_q == 4'h3) |-> $countones(data_out) == $countones(data_q));
   // R3
   arith_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == 4'hA && data_q[DATA_W-1]) |-> data_out[DATA_W-1]);
   // R6
   norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q >= 4'hD && data_q != '0 && data_q != '1) |-> data_out[DATA_W-1] != data_out[DATA_W-2]);
   // R7
   wr_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == 4'hE && !clr) |=> st0_q == $past(amt_out));
   // R8
   oe_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      amt_in_only |-> !amt_oe);
endmodule

// File: tb/norm_shifter_tb_top.sv
module norm_shifter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic [3:0]  op_in = '0;
   logic [15:0] data_in = '0;
   logic [3:0]  amt_in = '0;
   logic        amt_in_only = 1'b0;
   logic [15:0] data_out;
   logic [3:0]  amt_out;
   logic        amt_oe;

   int checks = 0;
   int errors = 0;
   logic [3:0] m_st0 = '0;
   logic [3:0] m_st1 = '0;

   always #10 clk = ~clk;

   norm_shifter dut_i (
      .clk (clk), .rst_n (rst_n), .clr (clr), .op_in (op_in), .data_in (data_in),
      .amt_in (amt_in), .amt_in_only (amt_in_only), .data_out (data_out),
      .amt_out (amt_out), .amt_oe (amt_oe)
   );

   function automatic logic [3:0] ref_enc(input logic [15:0] d);
      int n = 0;
      while (n < 15 && d[14-n] == d[15]) n++;
      return 4'(n);
   endfunction

   function automatic logic [15:0] ref_shift(input logic [3:0] op, input logic [15:0] d,
                                             input logic [3:0] c, input logic [3:0] s0,
                                             input logic [3:0] s1);
      logic [31:0] dd = {d, d};
      logic [31:0] rl = dd << c;
      logic [31:0] rr = dd >> c;
      case (op)
         4'h0: return d >> c;
         4'h1: return d << c;
         4'h2: return rr[15:0];
         4'h3: return rl[31:16];
         4'h4: return d >> s0;
         4'h5: return d << s0;
         4'h6: return d >> s1;
         4'h7: return d << s1;
         4'h8, 4'h9: return d;
         4'hA: return 16'($signed(d) >>> c);
         4'hB: return 16'($signed(d) >>> s0);
         4'hC: return 16'($signed(d) >>> s1);
         default: return d << ref_enc(d);
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'h0, 4'h1: return "R1";
         4'h2, 4'h3: return "R2";
         4'h4, 4'h5, 4'h6, 4'h7: return "R4";
         4'h8, 4'h9: return "R5";
         4'hA, 4'hB, 4'hC: return "R3";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one operation: drive on falling edge, sample one period later
   task automatic run(input logic [3:0] op, input logic [15:0] d, input logic [3:0] a,
                      input logic c, input string tag);
      logic [3:0]  a_eff;
      logic [15:0] exp_d;
      logic [3:0]  enc;
      logic        exp_oe;
      if (c) begin m_st0 = '0; m_st1 = '0; a_eff = '0; end  // R9
      else a_eff = a;
      exp_d  = ref_shift(op, d, a_eff, m_st0, m_st1);
      enc    = ref_enc(d);
      exp_oe = !amt_in_only && op >= 4'hD;
      if (op == 4'h8) m_st0 = a_eff;
      if (op == 4'h9) m_st1 = a_eff;
      if (op == 4'hE) m_st0 = enc;
      if (op == 4'hF) m_st1 = enc;
      op_in = op; data_in = d; amt_in = a; clr = c;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0;
      chk(tag == "" ? req_of(op) : tag, "data_out", 32'(data_out), 32'(exp_d));
      chk("R8", "amt_oe", 32'(amt_oe), 32'(exp_oe));
      if (exp_oe) chk("R8", "amt_out", 32'(amt_out), 32'(enc));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4417));
      // R10: inputs ignored during reset
      op_in = 4'h3; data_in = 16'hBEEF; amt_in = 4'h5;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "data_out in reset", 32'(data_out), 32'h0);
      chk("R10", "amt_oe in reset", 32'(amt_oe), 32'h0);
      rst_n = 1'b1;
      // R10: stores start at zero
      run(4'h4, 16'hF00F, 4'h7, 1'b0, "R10");
      run(4'h7, 16'h1234, 4'h7, 1'b0, "R10");
      // R1 / R2 / R3 directed corners
      run(4'h0, 16'h8001, 4'hF, 1'b0, "R1");
      run(4'h1, 16'h8001, 4'hF, 1'b0, "R1");
      run(4'h2, 16'h0001, 4'h1, 1'b0, "R2");
      run(4'h3, 16'h8000, 4'h1, 1'b0, "R2");
      run(4'h3, 16'hA5C3, 4'h0, 1'b0, "R2");
      run(4'hA, 16'h8000, 4'hF, 1'b0, "R3");
      run(4'hA, 16'h7FFF, 4'h3, 1'b0, "R3");
      // R5: load store 0/1 from count, then use them (R4)
      run(4'h8, 16'hC3C3, 4'h5, 1'b0, "R5");
      run(4'h9, 16'h0F0F, 4'hB, 1'b0, "R5");
      run(4'h4, 16'hFFFF, 4'h0, 1'b0, "R4");
      run(4'h7, 16'h0003, 4'h0, 1'b0, "R4");
      run(4'hB, 16'h8400, 4'h0, 1'b0, "R3");
      // R6: encoder corners
      run(4'hD, 16'h0000, 4'h0, 1'b0, "R6");
      run(4'hD, 16'hFFFF, 4'h0, 1'b0, "R6");
      run(4'hD, 16'h0001, 4'h0, 1'b0, "R6");
      run(4'hD, 16'hFFFE, 4'h0, 1'b0, "R6");
      run(4'hD, 16'h4000, 4'h0, 1'b0, "R6");
      run(4'hD, 16'hBFFF, 4'h0, 1'b0, "R6");
      // R7: normalise writes stores, seen through opcodes 5 and 6
      run(4'hE, 16'h0040, 4'h0, 1'b0, "R7");
      run(4'h5, 16'h0001, 4'h0, 1'b0, "R7");
      run(4'hF, 16'hFFF8, 4'h0, 1'b0, "R7");
      run(4'h6, 16'h8000, 4'h0, 1'b0, "R7");
      // R9: clear zeroes captured count and drops a pending write
      run(4'h8, 16'h0000, 4'h9, 1'b0, "R5");
      run(4'h0, 16'hF000, 4'hC, 1'b1, "R9");
      run(4'h4, 16'hF000, 4'h0, 1'b0, "R9");
      run(4'hE, 16'h0010, 4'h0, 1'b0, "R7");
      run(4'h5, 16'h0101, 4'h0, 1'b1, "R9");
      run(4'h5, 16'h0101, 4'h0, 1'b0, "R9");
      // R8: strap high blocks output enable
      amt_in_only = 1'b1;
      run(4'hD, 16'h0100, 4'h0, 1'b0, "R8");
      run(4'hF, 16'hFF00, 4'h0, 1'b0, "R8");
      amt_in_only = 1'b0;
      // random mix, both strap settings
      for (int k = 0; k < 600; k++) begin
         if (k == 300) amt_in_only = 1'b1;
         run(4'($urandom_range(15)), 16'($urandom()), 4'($urandom_range(15)),
             ($urandom_range(19) == 0), "");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule